// File: doc/BRIEF.md
# BCD Calendar Clock with Masked Alarm

This block keeps wall-clock time and a calendar in binary-coded decimal. It holds seconds, minutes, hours, day of week, date of month, month and a two-digit year. A one-cycle tick input advances the time, and one pulse on it stands for one second. A carry passes through the whole chain inside that single tick, so a tick at 23:59:59 on 31 December gives midnight on 1 January of the next year in the same clock cycle. February gets 29 days in every year whose two-digit value is a multiple of four.

Four alarm bytes hold seconds, minutes, hours and day of week. Each byte has its own "don't care" bit, which sets how often the alarm repeats. A match sets a sticky flag in the status byte. The interrupt pin follows that flag when the enable bit is set. The flag clears on any access to an alarm byte. A control byte stops the count and blocks writes to everything except itself. It also stores a two-bit selector that nothing inside this block uses.

Software reaches every byte through a flat parallel port: address, write data, write strobe, read strobe and read data. Read data is combinational from the addressed byte. A serial front end can sit on this port.

Top module: `rtc_core`

## Requirements
- R1: After reset, control (0Bh) reads 80h, seconds/minutes/hours/year read 00h, day of week/date/month read 01h, alarm bytes and status (0Ch) read 00h, and irq_o is low.
- R2: A counted tick adds one to seconds in BCD. Seconds 59 wrap to 00 and carry into minutes, and minutes 59 wrap to 00 and carry into hours, all in that one tick.
- R3: With hours bit 6 clear (24-hour), hours bits 5:0 count 00..23 in BCD. A carry out of 23 gives 00, steps day of week (07h wraps to 01h) and steps the date.
- R4: With hours bit 6 set (12-hour), bits 4:0 count 01..12 and bit 5 is PM. 11 to 12 toggles PM, and 12 to 01 keeps it. 11 PM to 12 AM carries into the day.
- R5: The date wraps to 01h after 30h in months 04h, 06h, 09h and 11h, and after 31h in all other months except February. Month 12h wraps to 01h and steps the year, and year 99h wraps to 00h.
- R6: February ends at 29h when the year register is a multiple of four (00h included), and at 28h otherwise.
- R7: While control bit 7 is 1, ticks leave all time and calendar bytes unchanged.
- R8: While control bit 6 is 1, writes to every address except control (0Bh) have no effect, and control writes still take effect.
- R9: Alarm bytes sit at 07h..0Ah (seconds, minutes, hours, day of week). Bit 7 of each is a mask. After a counted tick, status bit 0 is set when every unmasked alarm byte's bits 6:0 equal the matching time byte.
- R10: A read or write strobe to any address 07h..0Ah clears status bit 0 (a blocked write too), unless an alarm match sets it in the same cycle.
- R11: irq_o is high exactly while status bit 0 and control bit 0 are both 1.
- R12: Addresses 0Dh..7Fh read 00h. Unused bits read 0 (seconds/minutes 7 bits, hours 7, day of week 3, date 6, month 5, alarm day bits 7 and 2:0, control bits 7:4 and 0). Control bits 5:4 store and read back. Status ignores writes.
- R13: A write to any time or calendar byte (00h..06h) that takes effect in the same cycle as a tick wins, and that tick is dropped for the whole chain.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle pulse, one second of time |
| addr_i | input | ADDR_W (7) | Register address |
| wdata_i | input | 8 | Write data |
| wr_en_i | input | 1 | Write strobe, one cycle |
| rd_en_i | input | 1 | Read strobe, one cycle (used for flag clearing) |
| rdata_o | output | 8 | Read data of the addressed register, combinational |
| irq_o | output | 1 | Alarm interrupt, active high |

## Verification
A wrong carry or month length stays hidden in the state until the boundary tick. It then shows up on the read port in the very next cycle, as a wrong byte in the field past the boundary. A stuck or leaking alarm flag shows on irq_o one cycle after the tick or access that should have changed it. A corrupted control bit shows on the next tick (stopping or not) or the next blocked write. The bench checks the read port and the interrupt against its model on every cycle, so each such fault is caught within one clock of becoming visible.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int unsigned DATA_W  = 8;
    localparam int unsigned N_ALARM = 4;
    localparam int unsigned FIELD_W = 7;

    localparam int unsigned ADR_SEC   = 0;
    localparam int unsigned ADR_MIN   = 1;
    localparam int unsigned ADR_HOUR  = 2;
    localparam int unsigned ADR_DOW   = 3;
    localparam int unsigned ADR_DATE  = 4;
    localparam int unsigned ADR_MON   = 5;
    localparam int unsigned ADR_YEAR  = 6;
    localparam int unsigned ADR_ASEC  = 7;
    localparam int unsigned ADR_AMIN  = 8;
    localparam int unsigned ADR_AHOUR = 9;
    localparam int unsigned ADR_ADOW  = 10;
    localparam int unsigned ADR_CTRL  = 11;
    localparam int unsigned ADR_STAT  = 12;

    typedef struct packed {
        logic [6:0] sec;
        logic [6:0] min;
        logic [6:0] hour;
        logic [2:0] dow;
        logic [5:0] date;
        logic [4:0] mon;
        logic [7:0] year;
    } rtc_time_t;

    typedef struct packed {
        rtc_time_t  tm;
        logic [7:0] al_sec;
        logic [7:0] al_min;
        logic [7:0] al_hour;
        logic [3:0] al_dow;
        logic       osc_off;
        logic       wprot;
        logic [1:0] chsel;
        logic       aie;
        logic       irqf;
    } rtc_regs_t;

    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
        return {v[7:4], v[3:0] + 4'd1};
    endfunction

    // (10*t + o) mod 4 == (2*t + o) mod 4
    function automatic logic leap_year(input logic [7:0] y);
        logic [1:0] s;
        s = y[1:0] + {y[4], 1'b0};
        return s == 2'b00;
    endfunction

    function automatic logic [5:0] month_last(input logic [4:0] m, input logic leap);
        case (m)
            5'h02:                      return leap ? 6'h29 : 6'h28;
            5'h04, 5'h06, 5'h09, 5'h11: return 6'h30;
            default:                    return 6'h31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_time_step.sv
module rtc_time_step
    import rtc_pkg::*;
(
    input  rtc_time_t cur_i,
    output rtc_time_t nxt_o
);

    logic       c_min, c_hour, c_day, c_mon, c_year;
    logic [7:0] sec_inc, min_inc, hr_inc, date_inc, mon_inc, year_inc;
    logic [4:0] h12;
    logic       pm;

    always_comb begin
        nxt_o    = cur_i;
        sec_inc  = bcd_inc({1'b0, cur_i.sec});
        min_inc  = bcd_inc({1'b0, cur_i.min});
        date_inc = bcd_inc({2'b0, cur_i.date});
        mon_inc  = bcd_inc({3'b0, cur_i.mon});
        year_inc = bcd_inc(cur_i.year);
        h12      = cur_i.hour[4:0];
        pm       = cur_i.hour[5];
        hr_inc   = cur_i.hour[6] ? bcd_inc({3'b0, h12}) : bcd_inc({2'b0, cur_i.hour[5:0]});

        c_min  = (cur_i.sec == 7'h59);
        c_hour = c_min && (cur_i.min == 7'h59);
        c_day  = 1'b0;

        nxt_o.sec = c_min ? 7'h00 : sec_inc[6:0];
        if (c_min)
            nxt_o.min = c_hour ? 7'h00 : min_inc[6:0];

        if (c_hour) begin
            if (cur_i.hour[6]) begin
                if (h12 == 5'h11) begin
                    nxt_o.hour = {1'b1, ~pm, 5'h12};
                    c_day      = pm;
                end else if (h12 == 5'h12) begin
                    nxt_o.hour = {1'b1, pm, 5'h01};
                end else begin
                    nxt_o.hour = {1'b1, pm, hr_inc[4:0]};
                end
            end else begin
                if (cur_i.hour[5:0] == 6'h23) begin
                    nxt_o.hour = 7'h00;
                    c_day      = 1'b1;
                end else begin
                    nxt_o.hour = {1'b0, hr_inc[5:0]};
                end
            end
        end

        c_mon  = c_day && (cur_i.date == month_last(cur_i.mon, leap_year(cur_i.year)));
        c_year = c_mon && (cur_i.mon == 5'h12);

        if (c_day) begin
            nxt_o.dow  = (cur_i.dow == 3'd7) ? 3'd1 : cur_i.dow + 3'd1;
            nxt_o.date = c_mon ? 6'h01 : date_inc[5:0];
        end
        if (c_mon)
            nxt_o.mon = c_year ? 5'h01 : mon_inc[4:0];
        if (c_year)
            nxt_o.year = (cur_i.year == 8'h99) ? 8'h00 : year_inc;
    end

endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match #(
    parameter int unsigned N_FIELDS = 4,
    parameter int unsigned FW       = 7
) (
    input  logic [N_FIELDS-1:0][FW-1:0] field_i,
    input  logic [N_FIELDS-1:0][FW:0]   alarm_i,
    output logic                        hit_o
);

    logic [N_FIELDS-1:0] f_ok;

    for (genvar g = 0; g < N_FIELDS; g++) begin : g_field
        assign f_ok[g] = alarm_i[g][FW] || (alarm_i[g][FW-1:0] == field_i[g]);
    end

    assign hit_o = &f_ok;

endmodule

// File: rtl/rtc_core.sv
module rtc_core
    import rtc_pkg::*;
#(
    parameter int unsigned ADDR_W = 7
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              tick_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [7:0]        wdata_i,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    output logic [7:0]        rdata_o,
    output logic              irq_o
);

    localparam int unsigned LAST_TIME  = ADR_YEAR;
    localparam int unsigned FIRST_ALRM = ADR_ASEC;
    localparam int unsigned LAST_ALRM  = ADR_ADOW;

    rtc_regs_t r_d, r_q;
    rtc_time_t tm_next;
    logic      time_wr, adv, alm_acc, hit, wr_ok;
    int unsigned a;

    logic [N_ALARM-1:0][FIELD_W-1:0] cmp_field;
    logic [N_ALARM-1:0][FIELD_W:0]   cmp_alarm;

    rtc_time_step i_step (
        .cur_i (r_q.tm),
        .nxt_o (tm_next)
    );

    // compare against the time the tick is about to store
    assign cmp_field = {{4'b0, tm_next.dow}, tm_next.hour, tm_next.min, tm_next.sec};
    assign cmp_alarm = {{r_q.al_dow[3], 4'b0, r_q.al_dow[2:0]},
                        r_q.al_hour, r_q.al_min, r_q.al_sec};

    rtc_alarm_match #(
        .N_FIELDS (N_ALARM),
        .FW       (FIELD_W)
    ) i_match (
        .field_i (cmp_field),
        .alarm_i (cmp_alarm),
        .hit_o   (hit)
    );

    always_comb begin
        a       = int'(addr_i);
        wr_ok   = wr_en_i && !r_q.wprot;
        time_wr = wr_ok && (a <= LAST_TIME);
        adv     = tick_i && !r_q.osc_off && !time_wr;
        alm_acc = (rd_en_i || wr_en_i) && (a >= FIRST_ALRM) && (a <= LAST_ALRM);

        r_d = r_q;
        if (adv)
            r_d.tm = tm_next;
        if (alm_acc)
            r_d.irqf = 1'b0;
        if (adv && hit)
            r_d.irqf = 1'b1;

        if (wr_en_i && a == ADR_CTRL) begin
            r_d.osc_off = wdata_i[7];
            r_d.wprot   = wdata_i[6];
            r_d.chsel   = wdata_i[5:4];
            r_d.aie     = wdata_i[0];
        end else if (wr_ok) begin
            case (a)
                ADR_SEC:   r_d.tm.sec  = wdata_i[6:0];
                ADR_MIN:   r_d.tm.min  = wdata_i[6:0];
                ADR_HOUR:  r_d.tm.hour = wdata_i[6:0];
                ADR_DOW:   r_d.tm.dow  = wdata_i[2:0];
                ADR_DATE:  r_d.tm.date = wdata_i[5:0];
                ADR_MON:   r_d.tm.mon  = wdata_i[4:0];
                ADR_YEAR:  r_d.tm.year = wdata_i;
                ADR_ASEC:  r_d.al_sec  = wdata_i;
                ADR_AMIN:  r_d.al_min  = wdata_i;
                ADR_AHOUR: r_d.al_hour = wdata_i;
                ADR_ADOW:  r_d.al_dow  = {wdata_i[7], wdata_i[2:0]};
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q         <= '0;
            r_q.tm.dow  <= 3'd1;
            r_q.tm.date <= 6'h01;
            r_q.tm.mon  <= 5'h01;
            r_q.osc_off <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        case (int'(addr_i))
            ADR_SEC:   rdata_o = {1'b0, r_q.tm.sec};
            ADR_MIN:   rdata_o = {1'b0, r_q.tm.min};
            ADR_HOUR:  rdata_o = {1'b0, r_q.tm.hour};
            ADR_DOW:   rdata_o = {5'b0, r_q.tm.dow};
            ADR_DATE:  rdata_o = {2'b0, r_q.tm.date};
            ADR_MON:   rdata_o = {3'b0, r_q.tm.mon};
            ADR_YEAR:  rdata_o = r_q.tm.year;
            ADR_ASEC:  rdata_o = r_q.al_sec;
            ADR_AMIN:  rdata_o = r_q.al_min;
            ADR_AHOUR: rdata_o = r_q.al_hour;
            ADR_ADOW:  rdata_o = {r_q.al_dow[3], 4'b0, r_q.al_dow[2:0]};
            ADR_CTRL:  rdata_o = {r_q.osc_off, r_q.wprot, r_q.chsel, 3'b0, r_q.aie};
            ADR_STAT:  rdata_o = {7'b0, r_q.irqf};
            default:   rdata_o = 8'h00;
        endcase
    end

    assign irq_o = r_q.irqf && r_q.aie;

    AST_SEC_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (adv && r_q.tm.sec == 7'h59) |=> (r_q.tm.sec == 7'h00)); // R2
    AST_STOP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (r_q.osc_off && !wr_en_i) |=> $stable(r_q.tm)); // R7
    AST_WP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && r_q.wprot && a == ADR_SEC && !(tick_i && !r_q.osc_off))
        |=> $stable(r_q.tm.sec)); // R8
    AST_FLAG_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (adv && hit) |=> r_q.irqf); // R9
    AST_FLAG_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (alm_acc && !adv) |=> !r_q.irqf); // R10
    AST_RSV_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (int'(addr_i) > ADR_STAT) |-> (rdata_o == 8'h00)); // R12

endmodule

// File: tb/test_rtc_core.sv
module test_rtc_core;

    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic [6:0] addr = '0;
    logic [7:0] wdata = '0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] rdata;
    logic       irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    rtc_core i_rtc_core (
        .clk_i   (clk),
        .rst_ni  (rst_n),
        .tick_i  (tick),
        .addr_i  (addr),
        .wdata_i (wdata),
        .wr_en_i (wr_en),
        .rd_en_i (rd_en),
        .rdata_o (rdata),
        .irq_o   (irq)
    );

    // ---------------- behavioural reference model ----------------
    logic [7:0] m [0:12];

    function automatic int b2i(input logic [7:0] v);
        return int'(v[7:4]) * 10 + int'(v[3:0]);
    endfunction

    function automatic logic [7:0] i2b(input int v);
        return {4'(v / 10), 4'(v % 10)};
    endfunction

    function automatic logic [7:0] wmask(input int ad);
        case (ad)
            0, 1, 2: return 8'h7F;
            3:       return 8'h07;
            4:       return 8'h3F;
            5:       return 8'h1F;
            10:      return 8'h87;
            11:      return 8'hF1;
            default: return 8'hFF;
        endcase
    endfunction

    function automatic logic [7:0] m_read(input int ad);
        if (ad <= 12) return m[ad];
        return 8'h00;
    endfunction

    task automatic m_reset();
        for (int i = 0; i <= 12; i++) m[i] = 8'h00;
        m[3] = 8'h01; m[4] = 8'h01; m[5] = 8'h01; m[11] = 8'h80;
    endtask

    task automatic m_advance();
        int s, mi, h, pm, dw, dt, mo, yr, dim;
        bit cm, ch, cd, cmo, cy, hit;
        s = b2i(m[0]); mi = b2i(m[1]); dw = int'(m[3]);
        dt = b2i(m[4]); mo = b2i(m[5]); yr = b2i(m[6]);
        cm = 0; ch = 0; cd = 0; cmo = 0; cy = 0;
        if (s == 59) begin s = 0; cm = 1; end else s++;
        if (cm) begin if (mi == 59) begin mi = 0; ch = 1; end else mi++; end
        if (m[2][6]) begin
            h = b2i({3'b0, m[2][4:0]}); pm = int'(m[2][5]);
            if (ch) begin
                if (h == 11) begin h = 12; if (pm == 1) begin pm = 0; cd = 1; end else pm = 1; end
                else if (h == 12) h = 1;
                else h++;
            end
            m[2] = {2'b01, pm[0], 5'(i2b(h))};
        end else begin
            h = b2i({2'b0, m[2][5:0]});
            if (ch) begin if (h == 23) begin h = 0; cd = 1; end else h++; end
            m[2] = i2b(h);
        end
        if (mo == 2) dim = (yr % 4 == 0) ? 29 : 28;
        else if (mo == 4 || mo == 6 || mo == 9 || mo == 11) dim = 30;
        else dim = 31;
        if (cd) begin
            dw = (dw == 7) ? 1 : dw + 1;
            if (dt == dim) begin dt = 1; cmo = 1; end else dt++;
        end
        if (cmo) begin if (mo == 12) begin mo = 1; cy = 1; end else mo++; end
        if (cy) yr = (yr == 99) ? 0 : yr + 1;
        m[0] = i2b(s); m[1] = i2b(mi); m[3] = 8'(dw);
        m[4] = i2b(dt); m[5] = i2b(mo); m[6] = i2b(yr);
        hit = 1;
        for (int i = 0; i < 4; i++)
            if (!m[7+i][7] && (m[7+i][6:0] != m[i][6:0])) hit = 0;
        if (hit) m[12] = 8'h01;
    endtask

    task automatic m_step();
        int ad;
        bit wp, twr, adv, acc;
        ad  = int'(addr);
        wp  = m[11][6];
        twr = wr_en && !wp && ad <= 6;
        adv = tick && !m[11][7] && !twr;
        acc = (rd_en || wr_en) && ad >= 7 && ad <= 10;
        if (acc) m[12] = 8'h00;
        if (adv) m_advance();
        if (wr_en) begin
            if (ad == 11) m[11] = wdata & wmask(ad);
            else if (!wp && ad <= 10) m[ad] = wdata & wmask(ad);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) m_reset();
        else m_step();
        #3;
        if (rst_n && !done) begin
            checks++;
            if (rdata !== m_read(int'(addr))) begin
                errors++;
                $display("FAIL R12 per-cycle read @%0h: got %02h exp %02h", addr, rdata, m_read(int'(addr)));
            end
            checks++;
            if (irq !== (m[12][0] && m[11][0])) begin
                errors++;
                $display("FAIL R11 per-cycle irq: got %0b exp %0b", irq, m[12][0] && m[11][0]);
            end
        end
    end

    // ---------------- driver tasks ----------------
    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %02h exp %02h", req, got, exp);
        end
    endtask

    task automatic wr(input int ad, input logic [7:0] d);
        @(negedge clk);
        addr = 7'(ad); wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int ad, output logic [7:0] d);
        @(negedge clk);
        addr = 7'(ad); rd_en = 1'b1;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic expect_reg(input string req, input int ad, input logic [7:0] exp);
        logic [7:0] d;
        rd(ad, d);
        chk(req, d, exp);
    endtask

    task automatic do_tick();
        @(negedge clk);
        addr = 7'd12; tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic set_time(input logic [7:0] y, mo, dt, dw, h, mi, s);
        wr(6, y); wr(5, mo); wr(4, dt); wr(3, dw); wr(2, h); wr(1, mi); wr(0, s);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values
        expect_reg("R1 ctrl", 11, 8'h80);
        expect_reg("R1 sec", 0, 8'h00);
        expect_reg("R1 hour", 2, 8'h00);
        expect_reg("R1 dow", 3, 8'h01);
        expect_reg("R1 date", 4, 8'h01);
        expect_reg("R1 month", 5, 8'h01);
        expect_reg("R1 alarm sec", 7, 8'h00);
        expect_reg("R1 status", 12, 8'h00);
        chk("R1 irq", {7'b0, irq}, 8'h00);

        // R7 stopped clock ignores ticks
        do_tick(); do_tick();
        expect_reg("R7 sec held", 0, 8'h00);
        wr(11, 8'h00);
        do_tick();
        expect_reg("R7 running", 0, 8'h01);

        // R2 seconds/minutes carry
        set_time(8'h20, 8'h06, 8'h10, 8'h02, 8'h05, 8'h59, 8'h59);
        do_tick();
        expect_reg("R2 sec wrap", 0, 8'h00);
        expect_reg("R2 min wrap", 1, 8'h00);
        expect_reg("R2 hour step", 2, 8'h06);
        wr(0, 8'h09); do_tick();
        expect_reg("R2 bcd digit", 0, 8'h10);

        // R3 24-hour midnight and day-of-week wrap
        set_time(8'h20, 8'h03, 8'h15, 8'h07, 8'h23, 8'h59, 8'h59);
        do_tick();
        expect_reg("R3 hour", 2, 8'h00);
        expect_reg("R3 dow wrap", 3, 8'h01);
        expect_reg("R3 date", 4, 8'h16);

        // R4 12-hour mode
        set_time(8'h20, 8'h03, 8'h15, 8'h03, 8'h51, 8'h59, 8'h59);
        do_tick();
        expect_reg("R4 11AM->12PM", 2, 8'h72);
        expect_reg("R4 no day carry", 4, 8'h15);
        wr(1, 8'h59); wr(0, 8'h59); do_tick();
        expect_reg("R4 12PM->1PM", 2, 8'h61);
        set_time(8'h20, 8'h03, 8'h15, 8'h03, 8'h71, 8'h59, 8'h59);
        do_tick();
        expect_reg("R4 11PM->12AM", 2, 8'h52);
        expect_reg("R4 day carry", 4, 8'h16);

        // R5 month lengths and year rollover
        set_time(8'h20, 8'h04, 8'h30, 8'h01, 8'h23, 8'h59, 8'h59);
        do_tick();
        expect_reg("R5 30-day date", 4, 8'h01);
        expect_reg("R5 30-day month", 5, 8'h05);
        set_time(8'h20, 8'h01, 8'h30, 8'h01, 8'h23, 8'h59, 8'h59);
        do_tick();
        expect_reg("R5 31-day month", 4, 8'h31);
        set_time(8'h99, 8'h12, 8'h31, 8'h01, 8'h23, 8'h59, 8'h59);
        do_tick();
        expect_reg("R5 new-year date", 4, 8'h01);
        expect_reg("R5 new-year month", 5, 8'h01);
        expect_reg("R5 year wrap", 6, 8'h00);

        // R6 leap years
        set_time(8'h24, 8'h02, 8'h28, 8'h01, 8'h23, 8'h59, 8'h59);
        do_tick();
        expect_reg("R6 leap 28->29", 4, 8'h29);
        wr(2, 8'h23); wr(1, 8'h59); wr(0, 8'h59); do_tick();
        expect_reg("R6 leap 29->1", 4, 8'h01);
        expect_reg("R6 leap month", 5, 8'h03);
        set_time(8'h23, 8'h02, 8'h28, 8'h01, 8'h23, 8'h59, 8'h59);
        do_tick();
        expect_reg("R6 common year", 4, 8'h01);
        set_time(8'h00, 8'h02, 8'h28, 8'h01, 8'h23, 8'h59, 8'h59);
        do_tick();
        expect_reg("R6 year 00 leap", 4, 8'h29);

        // R8 write protect
        set_time(8'h20, 8'h05, 8'h05, 8'h05, 8'h10, 8'h20, 8'h30);
        wr(11, 8'h40);
        wr(0, 8'h11); wr(8, 8'h45);
        expect_reg("R8 sec blocked", 0, 8'h30);
        expect_reg("R8 alarm blocked", 8, 8'h00);
        wr(11, 8'h00);
        expect_reg("R8 ctrl writable", 11, 8'h00);

        // R13 write beats tick
        @(negedge clk);
        addr = 7'd0; wdata = 8'h40; wr_en = 1'b1; tick = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; tick = 1'b0;
        expect_reg("R13 write wins", 0, 8'h40);

        // R9 alarm, seconds match only
        set_time(8'h20, 8'h05, 8'h05, 8'h05, 8'h10, 8'h20, 8'h04);
        wr(7, 8'h05); wr(8, 8'h80); wr(9, 8'h80); wr(10, 8'h80);
        expect_reg("R9 flag clear before", 12, 8'h00);
        do_tick();
        expect_reg("R9 seconds match", 12, 8'h01);
        // R10 read of alarm clears
        expect_reg("R10 read alarm", 7, 8'h05);
        expect_reg("R10 cleared by read", 12, 8'h00);
        // R9 full match with day mismatch: no flag
        wr(7, 8'h06); wr(8, 8'h20); wr(9, 8'h10); wr(10, 8'h03);
        do_tick();
        expect_reg("R9 day mismatch", 12, 8'h00);
        // R9 full match
        wr(10, 8'h05); wr(7, 8'h07);
        do_tick();
        expect_reg("R9 full match", 12, 8'h01);
        // R11 enable gating
        chk("R11 irq off w/o enable", {7'b0, irq}, 8'h00);
        wr(11, 8'h01);
        chk("R11 irq on", {7'b0, irq}, 8'h01);
        // R10 write to alarm clears
        wr(9, 8'h90);
        chk("R10 cleared by write", {7'b0, irq}, 8'h00);
        // R9 every-second pattern
        wr(7, 8'h80); wr(8, 8'h80); wr(10, 8'h80);
        do_tick();
        chk("R9 every second", {7'b0, irq}, 8'h01);

        // R12 reserved, unused bits, selector, status
        expect_reg("R12 addr 0D", 13, 8'h00);
        expect_reg("R12 addr 20", 32, 8'h00);
        expect_reg("R12 addr 7F", 127, 8'h00);
        wr(4, 8'hFF);
        expect_reg("R12 date width", 4, 8'h3F);
        wr(11, 8'hBF);
        expect_reg("R12 ctrl bits", 11, 8'hB1);
        wr(11, 8'h31);
        wr(12, 8'h00);
        expect_reg("R12 status ro", 12, 8'h01);
        expect_reg("R12 selector", 11, 8'h31);

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule